// File: doc/BRIEF.md
# Debug Address Breakpoint Match Unit

This block watches a 32-bit core's execution for debug breakpoints. It holds no address registers of its own. The core presents four slot addresses and a control word, and the unit decodes from the control word, for each slot, an enable, a match kind and a span. In every cycle it compares the current instruction pointer against each execute-kind slot. When a memory data access is presented, it compares the access's byte range and direction against each data-kind slot.

When an evaluation is committed, the low status bits are rewritten. There is one bit per slot that matched, and a slot sets its bit even while it is disabled. The unit also raises a one-cycle debug trap request.

A commit happens in three cases:
- an enabled slot matched;
- the core forces the update;
- a single-step event arrives, which also sets a dedicated status flag and always requests the trap.

The core may load the status word directly when no commit happens in the same cycle.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: Slot i is enabled when control bit 2i (local) or control bit 2i+1 (global) is 1; either one alone is enough.
- R2: Slot i takes its kind from control bits [17+4i:16+4i] and its span from bits [19+4i:18+4i]. Span code 0 means 1 byte, 1 means 2 bytes, 2 means 8 bytes and 3 means 4 bytes.
- R3: Kind code 0 (execute) matches when `ip_valid` is 1 and the slot address equals `ip` exactly; the slot's span does not affect this match.
- R4: A data slot covers the span-byte region that starts at its address rounded down to a multiple of the span. The access covers `dacc_addr` up to `dacc_addr`+n-1, where `dacc_size` codes 0/1/2/3 give n = 1/2/4/8 bytes. The slot matches when the two regions share a byte. Kind 3 matches reads and writes; kind 1 matches writes only.
- R5: A kind 2 (I/O) slot never matches. An execute slot ignores data accesses, and data slots ignore the instruction pointer.
- R6: On a commit, status bits 3:0 become exactly the set of slots that matched in that cycle, including disabled ones. All other status bits keep their value, except bit 14 on a single step.
- R7: A commit happens only when an enabled slot matched, `force_upd` is 1 or `step_evt` is 1. `trap_req` is raised only when an enabled slot matched or `step_evt` is 1.
- R8: `step_evt` commits, sets status bit 14 and raises `trap_req`, even when no slot matched.
- R9: After reset, `status` is 0 and `trap_req` is 0.
- R10: When `st_wr_en` is 1 and no commit happens in that cycle, `status` takes `st_wr_data`; a commit in the same cycle wins.
- R11: `status` and `trap_req` are registered: they reflect the inputs of the preceding clock edge, and `trap_req` lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Breakpoint control word (enables, kinds, spans) |
| slot_addr | input | 128 | Four slot addresses, slot i in bits [32i+31:32i] |
| ip_valid | input | 1 | Instruction pointer is to be compared this cycle |
| ip | input | 32 | Current instruction pointer |
| dacc_valid | input | 1 | Data access present this cycle |
| dacc_addr | input | 32 | Data access start address |
| dacc_size | input | 2 | Access size code (1/2/4/8 bytes) |
| dacc_write | input | 1 | 1 for a write access, 0 for a read |
| force_upd | input | 1 | Force a status commit |
| step_evt | input | 1 | Single-step event |
| st_wr_en | input | 1 | Load status from `st_wr_data` |
| st_wr_data | input | 32 | Status load value |
| status | output | 32 | Debug status word |
| trap_req | output | 1 | Debug trap request, one cycle per event |

## Verification
The bench aims at several corner cases, each with a distinct failure it would expose:
- **Span code 2 versus code 3.** A unit that decoded span code 2 as four bytes would miss an access at the top of an 8-byte region.
- **Unaligned slot addresses and accesses that straddle a region edge.** A unit that forgot to align the slot address down would match or miss one byte off.
- **A disabled slot matching alongside an enabled one.** A unit that dropped disabled hits would lose status bits; one that trapped on them would fire spurious traps.
- **Reads on write-only slots, I/O-kind slots and the force input with nothing matched.** A wrong unit would set bits, or fail to clear bits 3:0, where the reference model expects otherwise.
- **Single-step and status-load collisions.** These check bit 14 and the commit-over-load priority.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

  // control word layout: enable pairs in the low byte, then 4-bit fields per slot
  localparam int unsigned KIND_LSB   = 16;
  localparam int unsigned SPAN_LSB   = 18;
  localparam int unsigned FIELD_STEP = 4;
  localparam int unsigned SPAN_W     = 4;

  typedef enum logic [1:0] {
    BK_EXEC = 2'd0,
    BK_DWR  = 2'd1,
    BK_IO   = 2'd2,
    BK_DRW  = 2'd3
  } bk_kind_e;

  typedef struct packed {
    logic                enabled;
    bk_kind_e            kind;
    logic [SPAN_W-1:0]   span;    // bytes covered: 1, 2, 4 or 8
  } slot_cfg_t;

  // slot span code to byte count (code 2 is the widest)
  function automatic logic [SPAN_W-1:0] span_of_code(input logic [1:0] code);
    case (code)
      2'd0:    return SPAN_W'(1);
      2'd1:    return SPAN_W'(2);
      2'd2:    return SPAN_W'(8);
      default: return SPAN_W'(4);
    endcase
  endfunction

  // access size code to byte count (power of two)
  function automatic logic [SPAN_W-1:0] bytes_of_size(input logic [1:0] code);
    return SPAN_W'(1) << code;
  endfunction

endpackage

// File: rtl/dbg_ctrl_decode.sv
module dbg_ctrl_decode
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CTRL_W    = 32
) (
  input  logic [CTRL_W-1:0]                ctrl_word,
  output slot_cfg_t [NUM_SLOTS-1:0]        cfg
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
    localparam int unsigned EN_LO = 2 * s;
    localparam int unsigned KD_LO = KIND_LSB + FIELD_STEP * s;
    localparam int unsigned SP_LO = SPAN_LSB + FIELD_STEP * s;
    always_comb begin
      cfg[s].enabled = ctrl_word[EN_LO] | ctrl_word[EN_LO + 1];
      cfg[s].kind    = bk_kind_e'(ctrl_word[KD_LO +: 2]);
      cfg[s].span    = span_of_code(ctrl_word[SP_LO +: 2]);
    end
  end

endmodule

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  slot_cfg_t          cfg,
  input  logic [ADDR_W-1:0]  slot_addr,
  input  logic               ip_valid,
  input  logic [ADDR_W-1:0]  ip,
  input  logic               dacc_valid,
  input  logic [ADDR_W-1:0]  dacc_addr,
  input  logic [1:0]         dacc_size,
  input  logic               dacc_write,
  output logic               hit
);

  // one extra bit so range ends never wrap
  localparam int EW = ADDR_W + 1;

  function automatic logic ranges_meet(input logic [EW-1:0] a_lo, input logic [EW-1:0] a_hi,
                                       input logic [EW-1:0] b_lo, input logic [EW-1:0] b_hi);
    return (a_lo <= b_hi) && (b_lo <= a_hi);
  endfunction

  logic [EW-1:0] span_ext, align_mask, reg_lo, reg_hi, acc_lo, acc_hi;
  logic          exec_hit, dir_ok, data_hit;

  always_comb begin
    span_ext   = EW'(cfg.span);
    align_mask = ~(span_ext - EW'(1));
    reg_lo     = {1'b0, slot_addr} & align_mask;
    reg_hi     = reg_lo + span_ext - EW'(1);
    acc_lo     = {1'b0, dacc_addr};
    acc_hi     = acc_lo + EW'(bytes_of_size(dacc_size)) - EW'(1);

    exec_hit = ip_valid && (cfg.kind == BK_EXEC) && (slot_addr == ip);
    dir_ok   = (cfg.kind == BK_DRW) || ((cfg.kind == BK_DWR) && dacc_write);
    data_hit = dacc_valid && dir_ok && ranges_meet(acc_lo, acc_hi, reg_lo, reg_hi);
    hit      = exec_hit | data_hit;
  end

endmodule

// File: rtl/dbg_status_upd.sv
module dbg_status_upd #(
  parameter int NUM_SLOTS = 4,
  parameter int ST_W      = 32,
  parameter int STEP_BIT  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] match_vec,
  input  logic [NUM_SLOTS-1:0] en_vec,
  input  logic                 force_upd,
  input  logic                 step_evt,
  input  logic                 st_wr_en,
  input  logic [ST_W-1:0]      st_wr_data,
  output logic [ST_W-1:0]      status,
  output logic                 trap_req,
  output logic                 en_hit,
  output logic                 commit
);

  logic [ST_W-1:0] fresh;

  always_comb begin
    en_hit = |(match_vec & en_vec);
    commit = en_hit | force_upd | step_evt;
    fresh  = {status[ST_W-1:NUM_SLOTS], match_vec};
    if (step_evt) fresh[STEP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      trap_req <= 1'b0;
    end else begin
      trap_req <= en_hit | step_evt;
      if (commit)        status <= fresh;
      else if (st_wr_en) status <= st_wr_data;
    end
  end

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int CTRL_W    = 32,
  parameter int ST_W      = 32,
  parameter int STEP_BIT  = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CTRL_W-1:0]           ctrl_word,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
  input  logic                        ip_valid,
  input  logic [ADDR_W-1:0]           ip,
  input  logic                        dacc_valid,
  input  logic [ADDR_W-1:0]           dacc_addr,
  input  logic [1:0]                  dacc_size,
  input  logic                        dacc_write,
  input  logic                        force_upd,
  input  logic                        step_evt,
  input  logic                        st_wr_en,
  input  logic [ST_W-1:0]             st_wr_data,
  output logic [ST_W-1:0]             status,
  output logic                        trap_req
);

  slot_cfg_t [NUM_SLOTS-1:0] cfg;
  logic [NUM_SLOTS-1:0]      match_vec;
  logic [NUM_SLOTS-1:0]      en_vec;
  logic                      en_hit;
  logic                      commit;

  dbg_ctrl_decode #(.NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_word (ctrl_word),
    .cfg       (cfg)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign en_vec[s] = cfg[s].enabled;
    dbg_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg        (cfg[s]),
      .slot_addr  (slot_addr[s*ADDR_W +: ADDR_W]),
      .ip_valid   (ip_valid),
      .ip         (ip),
      .dacc_valid (dacc_valid),
      .dacc_addr  (dacc_addr),
      .dacc_size  (dacc_size),
      .dacc_write (dacc_write),
      .hit        (match_vec[s])
    );
  end

  dbg_status_upd #(.NUM_SLOTS(NUM_SLOTS), .ST_W(ST_W), .STEP_BIT(STEP_BIT)) u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_vec  (match_vec),
    .en_vec     (en_vec),
    .force_upd  (force_upd),
    .step_evt   (step_evt),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .status     (status),
    .trap_req   (trap_req),
    .en_hit     (en_hit),
    .commit     (commit)
  );

endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int CTRL_W    = 32,
  parameter int ST_W      = 32,
  parameter int STEP_BIT  = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CTRL_W-1:0]    ctrl_word,
  input logic                 dacc_valid,
  input logic                 dacc_write,
  input logic                 step_evt,
  input logic                 st_wr_en,
  input logic [ST_W-1:0]      status,
  input logic                 trap_req,
  input logic [NUM_SLOTS-1:0] match_vec,
  input logic                 en_hit,
  input logic                 commit
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (trap_req == $past(en_hit | step_evt)));

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(commit) && !$past(st_wr_en)) |-> $stable(status));

  assert_step_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(step_evt)) |-> (status[STEP_BIT] && trap_req));

  assert_hit_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(commit)) |-> (status[NUM_SLOTS-1:0] == $past(match_vec)));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    localparam int KD = 16 + 4 * s;
    assert_io_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[KD +: 2] == 2'd2) |-> !match_vec[s]);
    assert_wr_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_word[KD +: 2] == 2'd1) && !(dacc_valid && dacc_write)) |-> !match_vec[s]);
  end

endmodule

bind dbg_bkpt_unit dbg_bkpt_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W), .ST_W(ST_W), .STEP_BIT(STEP_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_word  (ctrl_word),
  .dacc_valid (dacc_valid),
  .dacc_write (dacc_write),
  .step_evt   (step_evt),
  .st_wr_en   (st_wr_en),
  .status     (status),
  .trap_req   (trap_req),
  .match_vec  (match_vec),
  .en_hit     (en_hit),
  .commit     (commit)
);

// File: tb/sim_dbg_bkpt_unit.sv
module sim_dbg_bkpt_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  ctrl_word;
  logic [127:0] slot_addr;
  logic         ip_valid;
  logic [31:0]  ip;
  logic         dacc_valid;
  logic [31:0]  dacc_addr;
  logic [1:0]   dacc_size;
  logic         dacc_write;
  logic         force_upd;
  logic         step_evt;
  logic         st_wr_en;
  logic [31:0]  st_wr_data;
  logic [31:0]  status;
  logic         trap_req;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_status;
  logic        exp_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bkpt_unit u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .slot_addr(slot_addr),
    .ip_valid(ip_valid), .ip(ip), .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
    .dacc_size(dacc_size), .dacc_write(dacc_write), .force_upd(force_upd),
    .step_evt(step_evt), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .status(status), .trap_req(trap_req)
  );

  // behavioural reference: walks the access byte by byte
  function automatic int span_bytes(input int code);
    if (code == 2) return 8;
    if (code == 3) return 4;
    return code + 1;
  endfunction

  function automatic bit slot_hits(input int s);
    int kind, len;
    longint base, b;
    longint sa;
    kind = int'((ctrl_word >> (16 + 4*s)) & 3);
    len  = span_bytes(int'((ctrl_word >> (18 + 4*s)) & 3));
    sa   = longint'(slot_addr[s*32 +: 32]);
    if (kind == 0) return ip_valid && (sa == longint'(ip));
    if (kind == 2 || !dacc_valid) return 0;
    if (kind == 1 && !dacc_write) return 0;
    base = sa - (sa % len);
    for (int k = 0; k < (1 << dacc_size); k++) begin
      b = longint'(dacc_addr) + k;
      if (b >= base && b < base + len) return 1;
    end
    return 0;
  endfunction

  task automatic model_edge();
    bit [3:0] m;
    bit on_hit;
    on_hit = 0;
    for (int s = 0; s < 4; s++) begin
      m[s] = slot_hits(s);
      if (m[s] && (ctrl_word[2*s] || ctrl_word[2*s+1])) on_hit = 1;
    end
    exp_trap = on_hit || step_evt;
    if (on_hit || force_upd || step_evt) begin
      exp_status[3:0] = m;
      if (step_evt) exp_status[14] = 1'b1;
    end else if (st_wr_en) begin
      exp_status = st_wr_data;
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (status !== exp_status || trap_req !== exp_trap) begin
      n_bad++;
      $display("FAIL %s: status=%h trap=%b expected status=%h trap=%b",
               tag, status, trap_req, exp_status, exp_trap);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    ip_valid = 0; dacc_valid = 0; force_upd = 0; step_evt = 0; st_wr_en = 0;
  endtask

  task automatic set_slot(input int s, input logic [31:0] a);
    slot_addr[s*32 +: 32] = a;
  endtask

  function automatic logic [31:0] fld(input int s, input int kind, input int lc);
    return (32'(kind) << (16 + 4*s)) | (32'(lc) << (18 + 4*s));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ctrl_word = 0; slot_addr = '0; ip = 0; dacc_addr = 0;
    dacc_size = 0; dacc_write = 0; st_wr_data = 0;
    idle();
    exp_status = 0; exp_trap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare("R9 reset");

    // R1/R3: execute slot 0 local-enabled, slot 1 global-enabled
    set_slot(0, 32'h1000); set_slot(1, 32'h1200); set_slot(2, 32'h1000);
    ctrl_word = 32'h0000_0009 | fld(0,0,0) | fld(1,0,0) | fld(2,0,0);
    ip_valid = 1; ip = 32'h1000;
    cycle("R1 local enable + R6 disabled slot2 bit");
    ip = 32'h1200;
    cycle("R1 global enable");
    ip = 32'h1001;
    cycle("R3 exact ip mismatch");
    ip_valid = 0; ip = 32'h1000;
    cycle("R3 ip_valid low");
    ip_valid = 1; ctrl_word = fld(2,0,0);
    cycle("R7 disabled-only match holds status");
    force_upd = 1;
    cycle("R7 force commits disabled hit");
    ip_valid = 0;
    cycle("R6 force with no match clears low bits");
    idle();

    // R2/R4: data read/write slot, span code 2 = 8 bytes, unaligned address
    set_slot(0, 32'h2003); ctrl_word = 32'h1 | fld(0,3,2);
    dacc_valid = 1; dacc_write = 0; dacc_size = 0; dacc_addr = 32'h2007;
    cycle("R2 span code 2 top byte");
    dacc_addr = 32'h2008;
    cycle("R4 just past region");
    dacc_addr = 32'h1FFF; dacc_size = 1;
    cycle("R4 straddle low edge");
    // span code 3 = 4 bytes
    set_slot(0, 32'h2006); ctrl_word = 32'h1 | fld(0,3,3);
    dacc_addr = 32'h2002; dacc_size = 2;
    cycle("R2 span code 3 overlap");
    dacc_addr = 32'h2000;
    cycle("R2 span code 3 miss");
    // write-only slot
    ctrl_word = 32'h1 | fld(0,1,3); dacc_addr = 32'h2004; dacc_size = 0;
    cycle("R4 write-only ignores read");
    dacc_write = 1;
    cycle("R4 write-only write hits");
    // I/O kind and kind cross-checks
    ctrl_word = 32'h1 | fld(0,2,3); ip_valid = 1; ip = 32'h2006;
    cycle("R5 io kind silent");
    ctrl_word = 32'h1 | fld(0,0,0); dacc_addr = 32'h2006;
    ip = 32'h0;
    cycle("R5 exec slot ignores data");
    idle();

    // R8 single step, R10 status load
    step_evt = 1;
    cycle("R8 step sets flag and traps");
    idle(); st_wr_en = 1; st_wr_data = 32'hA5A5_0000;
    cycle("R10 status load");
    step_evt = 1; st_wr_data = 32'h0;
    cycle("R10 commit beats load");
    idle();
    cycle("R11 trap one cycle");

    // random phase over a small address window
    for (int i = 0; i < 3000; i++) begin
      ctrl_word = $urandom;
      for (int s = 0; s < 4; s++) set_slot(s, 32'h100 + ($urandom % 48));
      ip_valid   = $urandom_range(0, 1);
      ip         = 32'h100 + ($urandom % 48);
      dacc_valid = $urandom_range(0, 1);
      dacc_addr  = 32'h100 + ($urandom % 48);
      dacc_size  = 2'($urandom);
      dacc_write = $urandom_range(0, 1);
      force_upd  = ($urandom % 8) == 0;
      step_evt   = ($urandom % 16) == 0;
      st_wr_en   = ($urandom % 8) == 0;
      st_wr_data = $urandom;
      cycle("R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule